// File: doc/BRIEF.md
# Four-Bit Reversible-Cell Shifter

This block shifts a four-bit word by at most one position, entirely in combinational logic. A two-bit function code chooses the operation. The word can pass through unchanged, move one place toward the least significant end, move one place toward the most significant end, or be forced to zero. There are no registers, so a result appears in the same cycle as its operands.

Every result bit comes from its own six-line reversible cell. The cell's first output is a four-way selector. Its remaining outputs are parity and pass-through terms. The function code is not fanned out to the cells. Each cell's pass-through output carries the high code bit on to the next cell. The parity terms and the last cell's pass-through are not needed by the shift itself. They are brought out on a garbage bus, so the gate-level wiring can be checked from outside the block.

Top module: `rev_shift4`

## Requirements
- R1: With `func` = 2'b00 the result `q` equals the input `d`.
- R2: With `func` = 2'b01 the result is `d` shifted one place toward bit 0. Bit 3 of the result is 0.
- R3: With `func` = 2'b10 the result is `d` shifted one place toward bit 3. Bit 0 of the result is 0.
- R4: With `func` = 2'b11 every result bit is 0, whatever the value of `d`.
- R5: The cell's first output P selects one of its inputs using select lines E (high) and F (low):
  - EF = 00 selects A
  - EF = 01 selects B
  - EF = 10 selects C
  - EF = 11 selects D
- R6: The cell's other five outputs are:
  - Q = A^B^C
  - R = E^F
  - S = C^D
  - T = D^E^F
  - U = E
- R7: Result bit i comes from the P output of cell i. That cell's inputs are wired as follows:
  - A = d[i]
  - B = d[i+1], or 0 for the top bit
  - C = d[i-1], or 0 for bit 0
  - D = 0
  - E = the high code bit, which reaches cell i+1 through the U output of cell i
  - F = the low code bit
- R8: The garbage bus `junk` is 17 bits wide (four per cell plus one):
  - `junk[4i]` is Q of cell i
  - `junk[4i+1]` is R of cell i
  - `junk[4i+2]` is S of cell i
  - `junk[4i+3]` is T of cell i
  - `junk[16]` is U of the last cell, which equals `func[1]`

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| d | input | 4 | Data word |
| func | input | 2 | Function code: 00 pass, 01 shift toward bit 0, 10 shift toward bit 3, 11 clear |
| q | output | 4 | Shifted result |
| junk | output | 17 | Unused cell outputs, in the fixed order given in R8 |

## Verification
The hardest thing to observe from the ports is the select chain. The high code bit reaches each cell only through the pass-through output of the cell before it. A break in that chain only shows up when the high code bit differs between cells, which it never does in a correct block. It also only shows up in the last garbage bit and in the parity terms that mix the select lines. For that reason the stimulus covers every code against every data word, and every one of the 17 garbage bits is compared with a value computed for that input. The cell itself is stimulated directly through all 64 input patterns, because inside the shifter its D input is tied to 0 and can never be set.

// File: rtl/rev_sel6.sv
module rev_sel6 (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  input  logic e,
  input  logic f,
  output logic p,
  output logic q,
  output logic r,
  output logic s,
  output logic t,
  output logic u
);
  assign p = (~e & ((a & ~f) | (b & f))) | (e & ((c & ~f) | (d & f)));
  assign q = a ^ b ^ c;
  assign r = e ^ f;
  assign s = c ^ d;
  assign t = d ^ e ^ f;
  assign u = e;
endmodule

// File: rtl/rev_shift4.sv
module rev_shift4 #(
  parameter int W = 4,
  localparam int GW = 4 * W + 1
) (
  input  logic [W-1:0]  d,
  input  logic [1:0]    func,
  output logic [W-1:0]  q,
  output logic [GW-1:0] junk
);
  logic [W:0] echain;
  assign echain[0] = func[1];
  assign junk[GW-1] = echain[W];

  for (genvar i = 0; i < W; i++) begin : g_cell
    logic src_b, src_c;
    if (i == W - 1) begin : g_top
      assign src_b = 1'b0;
    end else begin : g_mid_b
      assign src_b = d[i+1];
    end
    if (i == 0) begin : g_bot
      assign src_c = 1'b0;
    end else begin : g_mid_c
      assign src_c = d[i-1];
    end
    rev_sel6 u_cell (
      .a(d[i]), .b(src_b), .c(src_c), .d(1'b0),
      .e(echain[i]), .f(func[0]),
      .p(q[i]),
      .q(junk[4*i]), .r(junk[4*i+1]), .s(junk[4*i+2]), .t(junk[4*i+3]),
      .u(echain[i+1])
    );
  end
endmodule

// File: rtl/rev_shift4_chk.sv
module rev_shift4_chk #(
  parameter int W = 4,
  localparam int GW = 4 * W + 1
) (
  input logic [W-1:0]  d,
  input logic [1:0]    func,
  input logic [W-1:0]  q,
  input logic [GW-1:0] junk
);
  always_comb begin
    if (!$isunknown({d, func, q, junk})) begin
      if (func == 2'b00) assert_pass_R1: assert (q == d);
      if (func == 2'b01) assert_shr_R2: assert (q == (d >> 1));
      if (func == 2'b10) assert_shl_R3: assert (q == W'(d << 1));
      if (func == 2'b11) assert_clear_R4: assert (q == '0);
      assert_chain_tail_R8: assert (junk[GW-1] == func[1]);
      assert_lsb_cell_R7: assert (junk[2] == 1'b0 && junk[1] == (func[1] ^ func[0])
                                  && junk[3] == junk[1]);
    end
  end
endmodule

bind rev_shift4 rev_shift4_chk #(.W(W)) u_chk (.d(d), .func(func), .q(q), .junk(junk));

// File: tb/tb_rev_shift4.sv
module tb_rev_shift4;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [3:0]  d;
  logic [1:0]  func;
  logic [3:0]  q;
  logic [16:0] junk;

  rev_shift4 dut (.d(d), .func(func), .q(q), .junk(junk));

  logic ga, gb, gc, gd, ge, gf;
  logic gp, gq, gr, gs, gt, gu;
  rev_sel6 u_gate (.a(ga), .b(gb), .c(gc), .d(gd), .e(ge), .f(gf),
                   .p(gp), .q(gq), .r(gr), .s(gs), .t(gt), .u(gu));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_shift(input logic [3:0] x, input logic [1:0] s);
    case (s)
      2'b00:   return x;
      2'b01:   return {1'b0, x[3:1]};
      2'b10:   return {x[2:0], 1'b0};
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic [16:0] ref_junk(input logic [3:0] x, input logic [1:0] s);
    logic [16:0] g;
    for (int i = 0; i < 4; i++) begin
      logic a, b, c;
      a = x[i];
      b = (i == 3) ? 1'b0 : x[(i+1)%4];
      c = (i == 0) ? 1'b0 : x[(i+3)%4];
      g[4*i]   = a ^ b ^ c;
      g[4*i+1] = s[1] ^ s[0];
      g[4*i+2] = c;
      g[4*i+3] = s[1] ^ s[0];
    end
    g[16] = s[1];
    return g;
  endfunction

  initial begin
    d = '0; func = '0;
    {ga, gb, gc, gd, ge, gf} = '0;
    @(posedge clk);
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 16; v++) begin
        @(posedge clk);
        d = v[3:0];
        func = s[1:0];
        @(negedge clk);
        case (s)
          0: check("R1 pass", 32'(q), 32'(ref_shift(v[3:0], 2'd0)));
          1: check("R2 shift toward bit0", 32'(q), 32'(ref_shift(v[3:0], 2'd1)));
          2: check("R3 shift toward bit3", 32'(q), 32'(ref_shift(v[3:0], 2'd2)));
          default: check("R4 clear", 32'(q), 32'h0);
        endcase
        check("R7 cell wiring junk", 32'(junk[15:0]), 32'(ref_junk(v[3:0], s[1:0]) & 17'h0FFFF));
        check("R8 chain tail junk[16]", 32'(junk[16]), 32'(s[1]));
      end
    end
    for (int k = 0; k < 64; k++) begin
      logic [5:0] x;
      logic ep;
      x = k[5:0];
      @(posedge clk);
      {ga, gb, gc, gd, ge, gf} = x;
      @(negedge clk);
      case (x[1:0])
        2'b00: ep = x[5];
        2'b01: ep = x[4];
        2'b10: ep = x[3];
        default: ep = x[2];
      endcase
      check("R5 cell selector", 32'(gp), 32'(ep));
      check("R6 cell side outputs", 32'({gq, gr, gs, gt, gu}),
            32'({x[5]^x[4]^x[3], x[1]^x[0], x[3]^x[2], x[2]^x[1]^x[0], x[1]}));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        bad++;
        checks++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule